// File: doc/BRIEF.md
# Two-Port Shared-Array Memory with Per-Port Word Widths

This block is a synchronous memory of 4096 bits that two independent clients reach at the same time. Each client has its own port, A or B, with its own clock, reset, enable, write select, address and data buses. A parameter sets each port's word width to 1, 2, 4, 8 or 16 bits. The depth of that port is 4096 divided by its width. Both ports see the same bits, so a word written through a narrow port can be read back as part of a wide word on the other port, and the reverse.

The contents at start-up come from a 4096-bit parameter. With the write selects tied low, the block works as a read-only table. Reads are registered. The read word appears on the port output after the clock edge that sampled the request. A write also places the written word on the writing port's own output.

The ports are plain memory ports with no handshake. A request is accepted on every clock edge where the port is enabled, and the block never pushes back. A client that needs flow control must provide it around the block.

Top module: `dpr_aspect_ram`

## Requirements
- R1: For a port of width W, word address n maps to array bits n*W through n*W+W-1. The word's least significant bit sits on the lowest array bit. With the defaults (A is 2 bits wide, B is 16 bits wide), A address n holds bits 2n and 2n+1, which are bits (2n mod 16) and (2n mod 16)+1 of B word n/8.
- R2: A word written through one port is returned by a later read through the other port, covering the write width and the read width that apply there.
- R3: A read of an address on a port returns the word that the same port wrote there on the previous edge, provided the other port has not written those bits since.
- R4: On an enabled write, the port's read output shows the written word after that edge (write-first).
- R5: While a port's enable is low, that port's write select has no effect on memory and its read output holds its value.
- R6: Before any write, array bit i holds bit i of the init parameter.
- R7: While a port's reset is low, its read output is cleared to zero at each clock edge. Reset does not change the memory contents.
- R8: A read output changes only at the port's own clock edge, one edge after the request is sampled.
- R9: Both ports may run at the same time on unrelated clocks. Every write to bits the other port is not writing at that moment takes effect.
- R10: Port depth is 4096/W, and the address width is log2(4096/W): 11 bits for A and 8 bits for B with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low, clears a_rdata |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write select (1 = write, 0 = read) |
| a_addr | input | log2(4096/WIDTH_A) | Port A word address |
| a_wdata | input | WIDTH_A | Port A write word |
| a_rdata | output | WIDTH_A | Port A registered read word |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low, clears b_rdata |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write select (1 = write, 0 = read) |
| b_addr | input | log2(4096/WIDTH_B) | Port B word address |
| b_wdata | input | WIDTH_B | Port B write word |
| b_rdata | output | WIDTH_B | Port B registered read word |

## Verification
The read-back assertion on each port assumes one thing about the inputs: between a port's write and its read of the same address on the next edge, the other port does not write any of those bits. The assertions also assume the two ports never write the same bit at the same instant. The stimulus meets both conditions in two ways. Whenever the ports run concurrently, port A stays in the lower half of the array and port B in the upper half. All other cross-port traffic runs one port at a time.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int TOTAL_BITS = 4096;
  localparam int ROW_W      = 16;
  localparam int ROWS       = TOTAL_BITS / ROW_W;
  localparam int ROW_AW     = $clog2(ROWS);
  localparam int BIT_AW     = $clog2(TOTAL_BITS);
  localparam int OFF_W      = $clog2(ROW_W);
endpackage

// File: rtl/dpr_bank.sv
// One XOR bank: written only from one port's clock, read combinationally at
// both ports' row indices. Stored word = bank0 ^ bank1.
module dpr_bank
  import dpr_pkg::*;
#(
  parameter logic [TOTAL_BITS-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_AW-1:0] wr_row,
  input  logic [ROW_W-1:0]  wr_val,
  input  logic [ROW_AW-1:0] rd_row_a,
  input  logic [ROW_AW-1:0] rd_row_b,
  output logic [ROW_W-1:0]  rd_val_a,
  output logic [ROW_W-1:0]  rd_val_b
);
  logic [ROW_W-1:0] mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) mem[r] = INIT[r*ROW_W +: ROW_W];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_val;
  end

  assign rd_val_a = mem[rd_row_a];
  assign rd_val_b = mem[rd_row_b];
endmodule

// File: rtl/dpr_lane.sv
// Per-port datapath: address-to-row decode, read-modify merge of the write
// word into its 16-bit row, word extraction, and the registered read output.
module dpr_lane
  import dpr_pkg::*;
#(
  parameter int W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          we,
  input  logic [BIT_AW-$clog2(W)-1:0]   addr,
  input  logic [W-1:0]                  wdata,
  input  logic [ROW_W-1:0]              row_cur,
  output logic [ROW_AW-1:0]             row_idx,
  output logic                          wr_go,
  output logic [ROW_W-1:0]              row_new,
  output logic [W-1:0]                  rdata
);
  localparam int SH = $clog2(W);

  logic [W-1:0] rd_word;

  generate
    if (W == ROW_W) begin : g_full_row
      assign row_idx = addr;
      assign row_new = wdata;
      assign rd_word = row_cur;
    end else begin : g_part_row
      logic [BIT_AW-1:0] bit_base;
      logic [OFF_W-1:0]  off;
      logic [ROW_W-1:0]  mask;
      logic [ROW_W-1:0]  wide;
      assign bit_base = BIT_AW'(addr) << SH;
      assign row_idx  = bit_base[BIT_AW-1:OFF_W];
      assign off      = bit_base[OFF_W-1:0];
      assign mask     = ROW_W'({W{1'b1}}) << off;
      assign wide     = ROW_W'(wdata) << off;
      assign row_new  = (row_cur & ~mask) | wide;
      assign rd_word  = W'(row_cur >> off);
    end
  endgenerate

  assign wr_go = en & we;

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (en) rdata <= we ? wdata : rd_word;
  end

  // R7: reset clears the read output
  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> rdata == '0);

  // R5: an idle port keeps its output
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));

  // R4: write-first on the writing port
  p_write_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |=> rdata == $past(wdata));

  // R3: read right after own write of the same address returns that word
  p_own_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we && $past(en && we) && addr == $past(addr))
      |=> rdata == $past(wdata, 2));
endmodule

// File: rtl/dpr_aspect_ram.sv
module dpr_aspect_ram
  import dpr_pkg::*;
#(
  parameter int                    WIDTH_A = 2,
  parameter int                    WIDTH_B = 16,
  parameter logic [TOTAL_BITS-1:0] INIT    = '0
) (
  input  logic                              clk_a,
  input  logic                              rst_a_n,
  input  logic                              a_en,
  input  logic                              a_we,
  input  logic [BIT_AW-$clog2(WIDTH_A)-1:0] a_addr,
  input  logic [WIDTH_A-1:0]                a_wdata,
  output logic [WIDTH_A-1:0]                a_rdata,
  input  logic                              clk_b,
  input  logic                              rst_b_n,
  input  logic                              b_en,
  input  logic                              b_we,
  input  logic [BIT_AW-$clog2(WIDTH_B)-1:0] b_addr,
  input  logic [WIDTH_B-1:0]                b_wdata,
  output logic [WIDTH_B-1:0]                b_rdata
);
  logic [ROW_AW-1:0] row_a, row_b;
  logic              go_a, go_b;
  logic [ROW_W-1:0]  new_a, new_b;
  logic [ROW_W-1:0]  k0_a, k0_b, k1_a, k1_b;
  logic [ROW_W-1:0]  cur_a, cur_b;

  assign cur_a = k0_a ^ k1_a;
  assign cur_b = k0_b ^ k1_b;

  dpr_lane #(.W(WIDTH_A)) u_lane_a (
    .clk(clk_a), .rst_n(rst_a_n), .en(a_en), .we(a_we), .addr(a_addr),
    .wdata(a_wdata), .row_cur(cur_a), .row_idx(row_a), .wr_go(go_a),
    .row_new(new_a), .rdata(a_rdata)
  );

  dpr_lane #(.W(WIDTH_B)) u_lane_b (
    .clk(clk_b), .rst_n(rst_b_n), .en(b_en), .we(b_we), .addr(b_addr),
    .wdata(b_wdata), .row_cur(cur_b), .row_idx(row_b), .wr_go(go_b),
    .row_new(new_b), .rdata(b_rdata)
  );

  // bank 0 owned by port A, carries the init image
  dpr_bank #(.INIT(INIT)) u_bank0 (
    .clk(clk_a), .wr_en(go_a), .wr_row(row_a), .wr_val(new_a ^ k1_a),
    .rd_row_a(row_a), .rd_row_b(row_b), .rd_val_a(k0_a), .rd_val_b(k0_b)
  );

  // bank 1 owned by port B, starts at zero
  dpr_bank #(.INIT('0)) u_bank1 (
    .clk(clk_b), .wr_en(go_b), .wr_row(row_b), .wr_val(new_b ^ k0_b),
    .rd_row_a(row_a), .rd_row_b(row_b), .rd_val_a(k1_a), .rd_val_b(k1_b)
  );
endmodule

// File: tb/dpr_aspect_ram_tb.sv
module dpr_aspect_ram_tb_top;
  localparam int WA = 2;
  localparam int WB = 16;

  function automatic logic [4095:0] make_init();
    logic [4095:0] v;
    for (int i = 0; i < 4096; i++) v[i] = (((i * 13) + (i >> 5)) % 3) == 0;
    return v;
  endfunction
  localparam logic [4095:0] INIT_PAT = make_init();

  logic clk_a = 0, clk_b = 0;
  logic rst_a_n = 0, rst_b_n = 0;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [10:0] a_addr = '0;
  logic [7:0]  b_addr = '0;
  logic [WA-1:0] a_wdata = '0, a_rdata;
  logic [WB-1:0] b_wdata = '0, b_rdata;

  logic [4095:0] ref_mem;
  logic [WA-1:0] exp_a = '0;
  logic [WB-1:0] exp_b = '0;
  int checks = 0, fails = 0;
  int seed = 32'h1F2E3D4C;

  always #10 clk_a = ~clk_a;      // 50 MHz
  initial begin #7; forever #15 clk_b = ~clk_b; end

  dpr_aspect_ram #(.WIDTH_A(WA), .WIDTH_B(WB), .INIT(INIT_PAT)) dut_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .a_en(a_en), .a_we(a_we),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_en(b_en), .b_we(b_we),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  function automatic int next_rand(inout int s);
    s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
    return s;
  endfunction

  // called at a negedge of clk_a; returns at the next negedge
  task automatic op_a(input logic en, input logic we, input logic [10:0] addr,
                      input logic [WA-1:0] data, input string tag);
    a_en = en; a_we = we; a_addr = addr; a_wdata = data;
    @(posedge clk_a);
    if (!rst_a_n) exp_a = '0;
    else if (en) begin
      if (we) begin ref_mem[int'(addr)*WA +: WA] = data; exp_a = data; end
      else exp_a = ref_mem[int'(addr)*WA +: WA];
    end
    @(negedge clk_a);
    checks++;
    if (a_rdata !== exp_a) begin
      fails++;
      $display("FAIL %s port A addr %0d: got %h expected %h", tag, addr, a_rdata, exp_a);
    end
  endtask

  task automatic op_b(input logic en, input logic we, input logic [7:0] addr,
                      input logic [WB-1:0] data, input string tag);
    b_en = en; b_we = we; b_addr = addr; b_wdata = data;
    @(posedge clk_b);
    if (!rst_b_n) exp_b = '0;
    else if (en) begin
      if (we) begin ref_mem[int'(addr)*WB +: WB] = data; exp_b = data; end
      else exp_b = ref_mem[int'(addr)*WB +: WB];
    end
    @(negedge clk_b);
    checks++;
    if (b_rdata !== exp_b) begin
      fails++;
      $display("FAIL %s port B addr %0d: got %h expected %h", tag, addr, b_rdata, exp_b);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ref_mem = INIT_PAT;
    // R7: outputs cleared while in reset; writes during reset still land
    fork
      begin
        @(negedge clk_a);
        for (int i = 0; i < 3; i++) op_a(1'b0, 1'b0, 11'd0, '0, "R7");
        rst_a_n = 1;
      end
      begin
        @(negedge clk_b);
        for (int i = 0; i < 3; i++) op_b(1'b0, 1'b0, 8'd0, '0, "R7");
        rst_b_n = 1;
      end
    join

    // R6/R10/R8: init image read at both widths, extremes of each address range
    op_b(1, 0, 8'd0,   '0, "R6");
    op_b(1, 0, 8'd1,   '0, "R6");
    op_b(1, 0, 8'd100, '0, "R6");
    op_b(1, 0, 8'd255, '0, "R10");
    @(negedge clk_a);
    op_a(1, 0, 11'd0,    '0, "R6");
    op_a(1, 0, 11'd5,    '0, "R6");
    op_a(1, 0, 11'd2047, '0, "R10");

    // R1/R2: A writes narrow words into row 1, B reads the whole row
    for (int i = 0; i < 8; i++) op_a(1, 1, 11'(8 + i), 2'(i), "R1");
    op_a(1, 1, 11'd2047, 2'b10, "R1");
    op_a(1, 1, 11'd0,    2'b01, "R1");
    op_a(0, 0, 11'd0, '0, "R5");
    @(negedge clk_b);
    op_b(1, 0, 8'd1,   '0, "R2");
    op_b(1, 0, 8'd255, '0, "R1");
    op_b(1, 0, 8'd0,   '0, "R1");

    // R2: B writes a row, A reads its eight pieces
    op_b(1, 1, 8'd200, 16'hC3A5, "R4");
    op_b(0, 0, 8'd0, '0, "R5");
    @(negedge clk_a);
    for (int i = 0; i < 8; i++) op_a(1, 0, 11'(1600 + i), '0, "R2");

    // R3/R4: own read-back on both ports
    op_a(1, 1, 11'd777, 2'b11, "R4");
    op_a(1, 0, 11'd777, '0,    "R3");
    @(negedge clk_b);
    op_b(1, 1, 8'd77, 16'h5A0F, "R4");
    op_b(1, 0, 8'd77, '0,       "R3");

    // R5: disabled writes change nothing, outputs hold
    op_b(0, 1, 8'd200, 16'hFFFF, "R5");
    op_b(0, 1, 8'd200, 16'h0000, "R5");
    op_b(1, 0, 8'd200, '0,       "R5");
    @(negedge clk_a);
    op_a(0, 1, 11'd777, 2'b00, "R5");
    op_a(1, 0, 11'd777, '0,    "R5");

    // R9: concurrent random traffic, A in lower half, B in upper half
    fork
      begin
        for (int i = 0; i < 120; i++) begin
          int r = next_rand(seed);
          op_a(r[0] | r[1], r[2], 11'(r[14:5] & 10'h3FF), 2'(r[21:20]), "R9");
        end
      end
      begin
        int s2 = 32'h0BADF00D;
        @(negedge clk_b);
        for (int i = 0; i < 80; i++) begin
          int r = next_rand(s2);
          op_b(r[0] | r[1], r[2], 8'(128 + r[12:6]), 16'(r[31:16]), "R9");
        end
      end
    join

    // R2/R9: full sweep of the array through port B
    @(negedge clk_b);
    for (int i = 0; i < 256; i++) op_b(1, 0, 8'(i), '0, "R9");

    // R7: reset clears the output but leaves memory intact
    rst_b_n = 0;
    op_b(0, 0, 8'd0, '0, "R7");
    rst_b_n = 1;
    op_b(1, 0, 8'd200, '0, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule